// File: doc/BRIEF.md
# Configurable Instruction Memory (RAM or ROM)

This block is the local instruction store of a processor. It sits on a simple request/response memory bus and owns an address window of `SIZE_BYTES` bytes starting at the bottom of instruction space (base 0x00000000). It decodes that window itself, so requests outside it are left for other devices. Every request inside the window is answered exactly one clock cycle after it is presented.

A single build-time parameter, `IS_ROM`, picks one of two variants. With `IS_ROM = 0` the storage is writable RAM with per-byte write enables and no defined power-up content, which suits a system where a loader fills memory at run time. With `IS_ROM = 1` the storage is a read-only table whose content is computed by a constant initializer inside the module. In this variant every store is answered with an error response instead of an acknowledge, and the processor turns that error into a store access fault.

Top module: `code_mem`

## Requirements
- R1: After reset, and before any request, `rsp_ack` and `rsp_err` are 0 and `rsp_rdata` is all zeros.
- R2: A request is inside the window when `req_addr[31:log2(SIZE_BYTES)]` equals the same bits of the base address 0x00000000. The word index is `req_addr[log2(SIZE_BYTES)-1:2]`, and `req_addr[1:0]` does not affect which word is accessed.
- R3: In RAM mode a write changes byte lane b (bits 8b+7 down to 8b) only when `req_be[b]` is 1. All other lanes keep their old value, and a write with `req_be` = 4'b0000 changes nothing.
- R4: Every request inside the window is answered in the clock cycle that follows the cycle in which it was presented, with `rsp_ack` or `rsp_err` high for exactly that one cycle.
- R5: A request outside the window produces no `rsp_ack`, no `rsp_err` and all-zero `rsp_rdata` in the following cycle, and it does not change the storage.
- R6: In ROM mode a write inside the window raises `rsp_err` (not `rsp_ack`) one cycle later and leaves the content unchanged.
- R7: `rsp_rdata` is all zeros in every cycle that does not acknowledge a read. This includes the acknowledge of a RAM write and the error response of a ROM write.
- R8: In ROM mode, word i holds (i * 32'h9E3779B1) ^ 32'h00000013, truncated to 32 bits.
- R9: `rsp_ack` and `rsp_err` are never high in the same cycle.
- R10: Requests may be issued back to back, one per cycle. A read in the cycle after a RAM write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the response logic |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Byte-lane write enables, bit b covers data bits 8b+7:8b |
| rsp_ack | output | 1 | Request of the previous cycle completed |
| rsp_err | output | 1 | Request of the previous cycle refused (ROM store) |
| rsp_rdata | output | 32 | Load data, zero unless a read is being acknowledged |

## Verification
On every cycle, the assertions check the response timing and exclusivity: a window hit is followed by exactly one of acknowledge or error, and a miss by neither. They also check that read data stays zero outside acknowledges and that a ROM store always ends in an error. Only the bench scenarios can show the storage itself working. These cover byte-lane merging, the computed ROM image, that ROM stores and out-of-window stores leave content untouched, address aliasing on the low two bits, and read-after-write across back-to-back requests. The bench runs a RAM instance and a ROM instance side by side on the same stimulus.

// File: rtl/code_mem_pkg.sv
package code_mem_pkg;

   localparam int BUS_W  = 32;
   localparam int LANE_W = 8;
   localparam int LANES  = BUS_W / LANE_W;

   typedef struct packed {
      logic             valid;
      logic             write;
      logic [BUS_W-1:0] addr;
      logic [BUS_W-1:0] wdata;
      logic [LANES-1:0] be;
   } mem_req_t;

   // constant initializer for the read-only variant
   function automatic logic [BUS_W-1:0] rom_word(input logic [BUS_W-1:0] idx);
      logic [BUS_W-1:0] v;
      v = idx * 32'h9E3779B1;
      return v ^ 32'h0000_0013;
   endfunction

endpackage

// File: rtl/code_mem_decode.sv
module code_mem_decode #(
   parameter int          ADDR_W     = 32,
   parameter int          SIZE_BYTES = 1024,
   parameter logic [31:0] BASE_ADDR  = 32'h0000_0000
) (
   input  logic                 valid,
   input  logic [ADDR_W-1:0]    addr,
   output logic                 hit,
   output logic [$clog2(SIZE_BYTES)-3:0] idx
);
   localparam int OFF_W = $clog2(SIZE_BYTES);

   logic [1:0] unused_lsb;
   assign unused_lsb = addr[1:0];

   // R2: compare upper bits against the base, word index below them
   assign hit = valid && (addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
   assign idx = addr[OFF_W-1:2];

endmodule

// File: rtl/code_mem_array.sv
module code_mem_array
   import code_mem_pkg::*;
#(
   parameter int SIZE_BYTES = 1024,
   parameter bit IS_ROM     = 1'b0
) (
   input  logic                   clk,
   input  logic                   acc_en,
   input  logic                   wr_en,
   input  logic [$clog2(SIZE_BYTES)-3:0] idx,
   input  logic [BUS_W-1:0]       wdata,
   input  logic [LANES-1:0]       be,
   output logic [BUS_W-1:0]       q
);
   localparam int IDX_W = $clog2(SIZE_BYTES) - 2;
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IS_ROM) begin : g_rom
         logic unused_wr;
         assign unused_wr = ^{wdata, be};

         always_ff @(posedge clk) begin
            if (acc_en) q <= rom_word(BUS_W'(idx));
         end

         // R6: the top must never pass a store into the read-only table
         a_r6_rom_no_store: assert property (@(posedge clk) !wr_en);
      end else begin : g_ram
         for (genvar b = 0; b < LANES; b++) begin : g_lane
            logic [LANE_W-1:0] lane_mem [DEPTH];
            always_ff @(posedge clk) begin
               if (wr_en && be[b]) lane_mem[idx] <= wdata[b*LANE_W +: LANE_W];
               if (acc_en)         q[b*LANE_W +: LANE_W] <= lane_mem[idx];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/code_mem_resp.sv
module code_mem_resp
   import code_mem_pkg::*;
#(
   parameter bit IS_ROM = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             write,
   input  logic [BUS_W-1:0] q,
   output logic             ack,
   output logic             err,
   output logic [BUS_W-1:0] rdata
);
   logic ack_q, err_q, rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         err_q <= 1'b0;
         rd_q  <= 1'b0;
      end else begin
         ack_q <= hit && !(IS_ROM && write);
         err_q <= hit && IS_ROM && write;
         rd_q  <= hit && !write;
      end
   end

   assign ack   = ack_q;
   assign err   = err_q;
   assign rdata = rd_q ? q : '0;

   // R9: completion and refusal are mutually exclusive
   a_r9_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && err));

endmodule

// File: rtl/code_mem.sv
module code_mem
   import code_mem_pkg::*;
#(
   parameter int          SIZE_BYTES = 1024,
   parameter logic [31:0] BASE_ADDR  = 32'h0000_0000,
   parameter bit          IS_ROM     = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [31:0] req_addr,
   input  logic [31:0] req_wdata,
   input  logic [3:0]  req_be,
   output logic        rsp_ack,
   output logic        rsp_err,
   output logic [31:0] rsp_rdata
);
   localparam int OFF_W = $clog2(SIZE_BYTES);
   localparam int IDX_W = OFF_W - 2;

   generate
      if ((SIZE_BYTES & (SIZE_BYTES - 1)) != 0 || SIZE_BYTES < 4) begin : g_bad_size
         initial $fatal(1, "code_mem: SIZE_BYTES must be a power of two >= 4");
      end
      if (OFF_W >= BUS_W) begin : g_bad_span
         initial $fatal(1, "code_mem: SIZE_BYTES must be below the address span");
      end
      if ((BASE_ADDR & (SIZE_BYTES - 1)) != 0) begin : g_bad_base
         initial $fatal(1, "code_mem: BASE_ADDR must be aligned to SIZE_BYTES");
      end
   endgenerate

   mem_req_t         req;
   logic             hit;
   logic [IDX_W-1:0] idx;
   logic [BUS_W-1:0] q;

   assign req = '{valid: req_valid, write: req_write, addr: req_addr,
                  wdata: req_wdata, be: req_be};

   code_mem_decode #(
      .ADDR_W(BUS_W), .SIZE_BYTES(SIZE_BYTES), .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .valid(req.valid), .addr(req.addr), .hit(hit), .idx(idx)
   );

   code_mem_array #(
      .SIZE_BYTES(SIZE_BYTES), .IS_ROM(IS_ROM)
   ) u_array (
      .clk(clk), .acc_en(hit), .wr_en(hit && req.write && !IS_ROM),
      .idx(idx), .wdata(req.wdata), .be(req.be), .q(q)
   );

   code_mem_resp #(
      .IS_ROM(IS_ROM)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .hit(hit), .write(req.write), .q(q),
      .ack(rsp_ack), .err(rsp_err), .rdata(rsp_rdata)
   );

   // R4: a window hit is answered in the next cycle
   a_r4_next_cycle_resp: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (rsp_ack || rsp_err));

   // R5: a miss or an idle cycle is followed by silence
   a_r5_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (!rsp_ack && !rsp_err && rsp_rdata == '0));

   // R7: data lines are zero whenever nothing is acknowledged
   a_r7_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_ack |-> rsp_rdata == '0);

   generate
      if (IS_ROM) begin : g_rom_chk
         // R6: every store inside the window ends in an error
         a_r6_store_refused: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && req_write) |=> (rsp_err && !rsp_ack));
      end else begin : g_ram_chk
         // R3: a RAM store is always acknowledged, never refused
         a_r3_store_accepted: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && req_write) |=> (rsp_ack && !rsp_err));
      end
   endgenerate

endmodule

// File: tb/code_mem_bench.sv
module code_mem_bench;
   localparam int SIZE = 1024;

   typedef struct {
      logic        a_ack, a_err;
      logic [31:0] a_dat;
      logic        o_ack, o_err;
      logic [31:0] o_dat;
      int          rid;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        ram_ack, ram_err, rom_ack, rom_err;
   logic [31:0] ram_dat, rom_dat;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb[$];
   logic [31:0] model [int];

   always #5 clk = ~clk;

   code_mem #(.SIZE_BYTES(SIZE), .IS_ROM(1'b0)) u_code_mem (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_ack(ram_ack), .rsp_err(ram_err), .rsp_rdata(ram_dat));

   code_mem #(.SIZE_BYTES(SIZE), .IS_ROM(1'b1)) u_code_mem_rom (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_ack(rom_ack), .rsp_err(rom_err), .rsp_rdata(rom_dat));

   function automatic logic [31:0] rom_img(input int i);
      logic [31:0] v;
      v = 32'(i) * 32'h9E3779B1;   // R8 formula
      return v ^ 32'h0000_0013;
   endfunction

   task automatic check(input int rid, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", rid, what, act, exp);
      end
   endtask

   // driver: present one request and push its expected response
   task automatic issue(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input int rid);
      exp_t e;
      bit   inw;
      int   ix;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      inw = (a < SIZE);
      ix  = int'(a[9:2]);
      e.rid   = rid;
      e.a_ack = inw;
      e.a_err = 1'b0;
      e.a_dat = (inw && !wr) ? model[ix] : 32'h0;
      e.o_ack = inw && !wr;
      e.o_err = inw && wr;
      e.o_dat = (inw && !wr) ? rom_img(ix) : 32'h0;
      if (inw && wr) begin
         logic [31:0] m;
         m = model.exists(ix) ? model[ix] : 32'h0;
         for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = d[b*8 +: 8];
         model[ix] = m;
      end
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // monitor: compare one cycle after each request is captured
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.rid, "ram ack", 32'(ram_ack), 32'(e.a_ack));
            check(e.rid, "ram err", 32'(ram_err), 32'(e.a_err));
            check(e.rid, "ram rdata", ram_dat, e.a_dat);
            check(e.rid, "rom ack", 32'(rom_ack), 32'(e.o_ack));
            check(e.rid, "rom err", 32'(rom_err), 32'(e.o_err));
            check(e.rid, "rom rdata", rom_dat, e.o_dat);
            check(9, "ack/err exclusive", 32'(ram_ack & ram_err | rom_ack & rom_err), 32'h0); // R9
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      // R1: quiet outputs straight after reset
      check(1, "reset ram ack", 32'(ram_ack), 32'h0);
      check(1, "reset ram err", 32'(ram_err), 32'h0);
      check(1, "reset ram rdata", ram_dat, 32'h0);
      check(1, "reset rom ack", 32'(rom_ack), 32'h0);
      check(1, "reset rom err", 32'(rom_err), 32'h0);
      check(1, "reset rom rdata", rom_dat, 32'h0);

      // R3/R4/R6: full-word stores, back to back
      for (int i = 0; i < 8; i++) issue(1'b1, 32'(i*4), 32'hC0DE_0000 + 32'(i*17), 4'hF, 3);
      // R7/R8: reads of the same words
      for (int i = 0; i < 8; i++) issue(1'b0, 32'(i*4), 32'h0, 4'h0, 8);
      // R3: partial lanes and an empty mask
      issue(1'b1, 32'h8, 32'hAABB_CCDD, 4'b0101, 3);
      issue(1'b1, 32'hC, 32'h1122_3344, 4'b1000, 3);
      issue(1'b1, 32'h10, 32'hFFFF_FFFF, 4'b0000, 3);
      idle();
      issue(1'b0, 32'h8, 32'h0, 4'h0, 3);
      issue(1'b0, 32'hC, 32'h0, 4'h0, 3);
      issue(1'b0, 32'h10, 32'h0, 4'h0, 3);
      // R2: low address bits do not select a different word
      issue(1'b0, 32'h9, 32'h0, 4'h0, 2);
      issue(1'b0, 32'hF, 32'h0, 4'h0, 2);
      // R2: top word of the window
      issue(1'b1, 32'(SIZE-4), 32'h5A5A_A5A5, 4'hF, 2);
      issue(1'b0, 32'(SIZE-4), 32'h0, 4'h0, 2);
      // R5: just past the window, far away, and an aliasing store
      issue(1'b0, 32'(SIZE), 32'h0, 4'h0, 5);
      issue(1'b0, 32'h8000_0000, 32'h0, 4'h0, 5);
      issue(1'b1, 32'(SIZE+8), 32'hDEAD_BEEF, 4'hF, 5);
      issue(1'b0, 32'h8, 32'h0, 4'h0, 5);
      // R10: store then load of the same word in consecutive cycles
      issue(1'b1, 32'h14, 32'h0BAD_F00D, 4'hF, 10);
      issue(1'b0, 32'h14, 32'h0, 4'h0, 10);
      issue(1'b1, 32'h14, 32'h7700_0000, 4'b1000, 10);
      issue(1'b0, 32'h14, 32'h0, 4'h0, 10);
      // R6/R8: ROM store then load shows unchanged image; deep ROM word
      issue(1'b1, 32'h20, 32'h1234_5678, 4'hF, 6);
      issue(1'b0, 32'h20, 32'h0, 4'h0, 6);
      issue(1'b0, 32'(SIZE-8), 32'h0, 4'h0, 8);
      idle();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule